// File: doc/BRIEF.md
# Interrupt Cause and Mask Aggregator

This block collects up to 29 hardware event lines into a 32-bit cause register. A software-writable mask register gates each cause bit. From the two registers the block drives one interrupt request line and the index of the pending source that should be serviced first. Sources occupy cause bit positions 1 to 29. The three remaining positions are read-only summary bits, each formed over a fixed group of sources.

Software reaches both registers over a simple single-cycle register bus. Cause is at byte offset 0x0 and mask at 0x4. Read data is registered. A source is acknowledged by writing 0 to its cause bit while the other bits are written back as 1 or with their current value, so one write never clears another source by accident. An event line held high keeps setting its cause bit, so a source stays pending until it is both deasserted and acknowledged.

Top module: `evtc_top`

## Requirements
- R1: After a synchronous reset, the cause and mask registers read 0x00000000, irq_o is 0, pend_vld_o is 0 and pend_idx_o is 0.
- R2: If evt_i[s] (s from 1 to 29) is high at a clock edge, cause bit s is 1 after that edge.
- R3: A write to offset 0x0 clears cause bit s (1..29) when data bit s is 0. A data bit of 1 leaves the cause bit unchanged and never sets it.
- R4: If evt_i[s] is high in the same cycle as a write that clears cause bit s, the bit stays set.
- R5: Cause bits 0, 30 and 31 ignore writes and are computed from the unmasked source bits. Bit 0 is the OR of bits 29..1. Bit 30 is the OR of bits 29..26 and 20..1. Bit 31 is the OR of bits 25..1.
- R6: The mask register at offset 0x4 stores bits 29..1 as written. Mask bits 0, 30 and 31 always read 0.
- R7: irq_o is 1 exactly when, one cycle earlier, the AND of cause and mask had any bit in positions 1..29 set.
- R8: pend_vld_o follows irq_o. While it is 1, pend_idx_o gives the lowest set position of cause AND mask, and the lowest index wins. While it is 0, pend_idx_o is 0.
- R9: bus_rdata holds the addressed register as it was before the edge on which bus_rd was sampled high. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 29 | Event lines, bit s feeds cause bit s (indices 29..1) |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |
| pend_idx_o | output | 5 | Registered index of the first pending source |
| pend_vld_o | output | 1 | Registered flag that pend_idx_o is meaningful |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address with cause at 0x0 and mask at 0x4. This exposes the full 29-source map. The test sources sit on the group boundaries 1, 20/21, 25/26 and 29, so each summary bit is seen both set and clear. Priority is exercised with two masked sources and with the two extreme indices, 1 and 29. An unmapped offset at 0x8 checks the zero read-back.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int DATA_W   = 32;
  localparam int NSRC     = 29;
  localparam int IDX_W    = $clog2(NSRC + 1);
  // summary bit positions inside the cause word
  localparam int SUM_ALL  = 0;
  localparam int SUM_LOW  = 30;
  localparam int SUM_MID  = 31;
  // source group bounds for the summary bits
  localparam int LOW_TOP_HI = 29;
  localparam int LOW_TOP_LO = 26;
  localparam int LOW_BOT_HI = 20;
  localparam int MID_HI     = 25;
endpackage

// File: rtl/evtc_cause_reg.sv
module evtc_cause_reg #(
  parameter int N = 29
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N:1]   set_i,
  input  logic [N:1]   clr_i,
  output logic [N:1]   q_o
);
  for (genvar i = 1; i <= N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evtc_summary.sv
module evtc_summary
  import evtc_pkg::*;
(
  input  logic [NSRC:1]     src_i,
  output logic [DATA_W-1:0] word_o
);
  logic s_all, s_low, s_mid;
  always_comb begin
    s_all = |src_i;
    s_low = (|src_i[LOW_TOP_HI:LOW_TOP_LO]) | (|src_i[LOW_BOT_HI:1]);
    s_mid = |src_i[MID_HI:1];
    word_o = '0;
    word_o[NSRC:1]  = src_i;
    word_o[SUM_ALL] = s_all;
    word_o[SUM_LOW] = s_low;
    word_o[SUM_MID] = s_mid;
  end
endmodule

// File: rtl/evtc_prio_enc.sv
module evtc_prio_enc #(
  parameter int N     = 29,
  parameter int IDX_W = 5
) (
  input  logic [N:1]       req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    for (int i = N; i >= 1; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/evtc_top.sv
module evtc_top
  import evtc_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h04
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC:1]        evt_i,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     pend_idx_o,
  output logic                 pend_vld_o
);
  logic            sel_cause, sel_mask;
  logic [NSRC:1]   cause_src, mask_src, clr_vec, pend_vec;
  logic [DATA_W-1:0] cause_word, mask_word, rd_mux;
  logic [IDX_W-1:0]  enc_idx;
  logic              enc_any;
  logic              unused_wbits;

  assign sel_cause = (bus_addr == CAUSE_OFS);
  assign sel_mask  = (bus_addr == MASK_OFS);
  assign clr_vec   = (bus_wr && sel_cause) ? ~bus_wdata[NSRC:1] : '0;
  assign unused_wbits = ^{bus_wdata[SUM_ALL], bus_wdata[DATA_W-1:NSRC+1]};

  evtc_cause_reg #(.N(NSRC)) u_cause (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(clr_vec), .q_o(cause_src)
  );

  always_ff @(posedge clk) begin
    if (rst)                     mask_src <= '0;
    else if (bus_wr && sel_mask) mask_src <= bus_wdata[NSRC:1];
  end

  evtc_summary u_sum (.src_i(cause_src), .word_o(cause_word));

  always_comb begin
    mask_word = '0;
    mask_word[NSRC:1] = mask_src;
  end

  assign pend_vec = cause_src & mask_src;

  evtc_prio_enc #(.N(NSRC), .IDX_W(IDX_W)) u_enc (
    .req_i(pend_vec), .idx_o(enc_idx), .any_o(enc_any)
  );

  always_comb begin
    if (sel_cause)     rd_mux = cause_word;
    else if (sel_mask) rd_mux = mask_word;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      irq_o      <= 1'b0;
      pend_idx_o <= '0;
      pend_vld_o <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_o      <= enc_any;
      pend_idx_o <= enc_idx;
      pend_vld_o <= enc_any;
    end
  end
endmodule

// File: rtl/evtc_chk.sv
module evtc_chk
  import evtc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h00
) (
  input logic                clk,
  input logic                rst,
  input logic [NSRC:1]       evt_i,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq_o,
  input logic [IDX_W-1:0]    pend_idx_o,
  input logic                pend_vld_o,
  input logic [NSRC:1]       cause_src,
  input logic [NSRC:1]       mask_src
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_o && !pend_vld_o && cause_src == '0 && mask_src == '0));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((cause_src & $past(evt_i)) == $past(evt_i)));

  a_r5_any_summary: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CAUSE_OFS) |=> (bus_rdata[SUM_ALL] == $past(|cause_src)));

  a_r7_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(cause_src & mask_src))));

  a_r8_vld_is_irq: assert property (@(posedge clk) disable iff (rst)
    pend_vld_o == irq_o);

  a_r8_idx_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !pend_vld_o |-> (pend_idx_o == '0));
endmodule

bind evtc_top evtc_chk #(.ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .pend_idx_o(pend_idx_o),
  .pend_vld_o(pend_vld_o), .cause_src(cause_src), .mask_src(mask_src)
);

// File: tb/evtc_top_bench.sv
module evtc_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:1] evt = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, vld;
  logic [4:0]  idx;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  evtc_top u_evtc_top (
    .clk(clk), .rst(rst), .evt_i(evt), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq),
    .pend_idx_o(idx), .pend_vld_o(vld)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(posedge clk); #1 d = rdata; rd = 1'b0;
  endtask

  task automatic pulse(logic [29:1] v);
    @(negedge clk); evt = v;
    @(posedge clk); #1 evt = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [29:1] s(int n);
    return 29'(1) << (n - 1);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 vld", {31'b0, vld}, 0);
    check("R1 idx", {27'b0, idx}, 0);
    reg_rd(8'h00, d); check("R1 cause", d, 32'h0);
    reg_rd(8'h04, d); check("R1 mask", d, 32'h0);
  endtask

  task automatic t_latch_clear();
    logic [31:0] d;
    pulse(s(5));
    reg_rd(8'h00, d); check("R2 src5 latched, R5 summaries", d, 32'hC000_0021);
    reg_wr(8'h00, 32'hFFFF_FFDF);
    reg_rd(8'h00, d); check("R3 clear src5", d, 32'h0);
    pulse(s(22));
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, d); check("R3 write ones no effect", d, 32'h8040_0001);
    reg_wr(8'h00, 32'hFFBF_FFFF);
    reg_rd(8'h00, d); check("R3 clear src22", d, 32'h0);
  endtask

  task automatic t_groups();
    logic [31:0] d;
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, d); check("R5 summary bits ignore writes", d, 32'h0);
    pulse(s(26)); reg_rd(8'h00, d); check("R5 src26", d, 32'h4400_0001);
    reg_wr(8'h00, 32'h0);
    pulse(s(21)); reg_rd(8'h00, d); check("R5 src21", d, 32'h8020_0001);
    reg_wr(8'h00, 32'h0);
    pulse(s(29)); reg_rd(8'h00, d); check("R5 src29", d, 32'h6000_0001);
    reg_wr(8'h00, 32'h0);
    pulse(s(1));  reg_rd(8'h00, d); check("R5 src1", d, 32'hC000_0003);
    reg_wr(8'h00, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk); evt = s(3);
    reg_wr(8'h00, 32'h0);
    evt = '0;
    reg_rd(8'h00, d); check("R4 set beats clear", d, 32'hC000_0009);
    reg_wr(8'h00, 32'h0);
    reg_rd(8'h00, d); check("R4 later clear", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    reg_wr(8'h04, 32'hFFFF_FFFF);
    reg_rd(8'h04, d); check("R6 mask readback", d, 32'h3FFF_FFFE);
    reg_wr(8'h04, 32'h0);
    reg_rd(8'h04, d); check("R6 mask cleared", d, 32'h0);
  endtask

  task automatic t_prio();
    pulse(s(7) | s(12));
    tick(); tick();
    check("R7 masked sources no irq", {31'b0, irq}, 0);
    check("R8 idle idx", {27'b0, idx}, 0);
    reg_wr(8'h04, {2'b0, s(12), 1'b0});
    tick();
    check("R7 irq on unmask", {31'b0, irq}, 1);
    check("R8 vld", {31'b0, vld}, 1);
    check("R8 idx 12", {27'b0, idx}, 12);
    reg_wr(8'h04, {2'b0, s(12) | s(7), 1'b0});
    tick();
    check("R8 lower idx 7 wins", {27'b0, idx}, 7);
    reg_wr(8'h00, 32'h0);
    tick();
    check("R7 irq drops after ack", {31'b0, irq}, 0);
    reg_wr(8'h04, 32'hFFFF_FFFF);
    pulse(s(1) | s(29));
    tick();
    check("R8 idx 1 first", {27'b0, idx}, 1);
    reg_wr(8'h00, 32'hFFFF_FFFD);
    tick();
    check("R8 idx 29 after ack of 1", {27'b0, idx}, 29);
    check("R7 irq still high", {31'b0, irq}, 1);
    reg_wr(8'h00, 32'h0);
    reg_wr(8'h04, 32'h0);
    tick();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    pulse(s(9));
    reg_rd(8'h08, d); check("R9 unmapped reads 0", d, 32'h0);
    reg_rd(8'h00, d); check("R9 cause read", d, 32'hC000_0201);
    reg_wr(8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_latch_clear();
    t_groups();
    t_set_wins();
    t_mask();
    t_prio();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule